// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

The block collects interrupt requests from eight device lines and passes one at a time to a processor. A rising edge on a request line marks the line pending. Pending lines that are not masked compete by fixed priority. The winner raises a single interrupt output. The processor then replies with two active-low acknowledge pulses. The first pulse takes the request: the interrupt output drops and the line moves from pending to in-service. While the second pulse is low, the controller drives the line's vector number onto an 8-bit bus. That number is the line index added to a programmable base.

A line that is in service cannot be presented again until software finishes its handling with an end-of-interrupt write. A higher-priority line can still interrupt the handler that is running. Software uses a small write port to set the per-line mask, the vector base and the end-of-interrupt command.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `int_out` is 0, `vec_oe` is 0, `vec_out` is 0, no line is masked and the vector base is 32.
- R2: A 0-to-1 transition on `irq_req[i]` marks line i pending. A request held high after it has been served does not raise `int_out` again.
- R3: A write with `wr_addr`=0 loads the mask, where bit i set to 1 masks line i. A masked pending line never raises `int_out`.
- R4: Among the eligible pending lines, the lowest index wins (line 0 first, line 7 last).
- R5: Suppose no handshake is in progress. If an eligible line exists at a clock edge, `int_out` is high after the next edge. It stays high until `ack_n` is sampled low.
- R6: When `ack_n` is sampled low while `int_out` is high, `int_out` is low after that edge. The chosen line moves from pending to in-service.
- R7: `vec_oe` is 1 only while `ack_n` is low during the second acknowledge pulse. At that time `vec_out` equals base + line index. At every other time `vec_oe` is 0 and `vec_out` is 0.
- R8: A write with `wr_addr`=1 loads the vector base from `wr_data`. The sum base + index wraps modulo 256.
- R9: A line that is in service is not presented again before an end-of-interrupt write, even if it sees a new rising edge. That edge stays pending.
- R10: A pending line can interrupt only when its index is lower than every in-service index.
- R11: A write with `wr_addr`=2 (data ignored) clears the lowest-indexed in-service bit. If an eligible line then exists, `int_out` is high after the following edge.
- R12: If the presented line becomes ineligible (for example, it is masked) before the first acknowledge, `int_out` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Device request lines, edge-detected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = mask, 1 = vector base, 2 = end of interrupt |
| wr_data | input | 8 | Write data |
| ack_n | input | 1 | Active-low acknowledge from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector number, zero when not enabled |
| vec_oe | output | 1 | Vector output enable |

## Verification
The hardest state to reach is nesting. One line must already be in service while a lower-indexed line interrupts it, and then the end-of-interrupt write must release the correct one of the two in-service bits. The stimulus serves line 5 and, without retiring it, pulses line 2 and serves that. It then issues one end-of-interrupt write and pulses line 3. Line 3 can be presented only if line 2, and not line 5, was released. The bench also pulses line 6, which stays blocked until line 5 is retired. Re-entry is reached in a similar way: a line is given a second edge while it is still in service.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned VEC_W = 8;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_ARMED,
    HS_FIRST,
    HS_GAP,
    HS_SECOND
  } hs_state_t;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_BASE = 2'd1,
    REG_EOI  = 2'd2
  } reg_sel_t;
endpackage

// File: rtl/irqc_lines.sv
module irqc_lines #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] take,
  input  logic         eoi,
  output logic [N-1:0] pending,
  output logic [N-1:0] in_svc
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;
  logic [N-1:0] eoi_clr;

  function automatic logic [N-1:0] lowest_onehot(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  assign rise    = req & ~req_q;
  assign eoi_clr = eoi ? lowest_onehot(in_svc) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      pending <= '0;
      in_svc  <= '0;
    end else begin
      req_q   <= req;
      pending <= (pending & ~take) | rise;
      in_svc  <= (in_svc & ~eoi_clr) | take;
    end
  end

  assert_take_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
  assert_no_reenter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take & in_svc) == '0);
  assert_take_from_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~pending) == '0);
  assert_eoi_clears_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && in_svc != '0 && take == '0) |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pending,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  in_svc,
  output logic          cand_valid,
  output logic [IW-1:0] cand_idx
);
  logic [N-1:0] below_svc;
  logic [N-1:0] eligible;

  for (genvar i = 0; i < N; i++) begin : g_ceiling
    assign below_svc[i] = ~|in_svc[i:0];
  end

  function automatic logic [IW-1:0] first_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (v[k]) r = IW'(k);
    end
    return r;
  endfunction

  assign eligible   = pending & ~mask & below_svc;
  assign cand_valid = |eligible;
  assign cand_idx   = first_set(eligible);
endmodule

// File: rtl/irqc_handshake.sv
module irqc_handshake
  import irqc_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned VW = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cand_valid,
  input  logic [IW-1:0] cand_idx,
  input  logic          ack_n,
  input  logic [VW-1:0] base,
  output logic [N-1:0]  take,
  output logic          int_out,
  output logic [VW-1:0] vec_out,
  output logic          vec_oe
);
  hs_state_t     st, st_n;
  logic [IW-1:0] sel;
  logic          grab;

  function automatic logic [VW-1:0] vec_calc(input logic [VW-1:0] b, input logic [IW-1:0] idx);
    return b + VW'(idx);
  endfunction

  assign grab    = (st == HS_ARMED) && cand_valid && !ack_n;
  assign take    = grab ? (N'(1) << cand_idx) : '0;
  assign int_out = (st == HS_ARMED);
  assign vec_oe  = !ack_n && ((st == HS_GAP) || (st == HS_SECOND));
  assign vec_out = vec_oe ? vec_calc(base, sel) : '0;

  always_comb begin
    st_n = st;
    unique case (st)
      HS_IDLE:   if (cand_valid) st_n = HS_ARMED;
      HS_ARMED:  if (!cand_valid) st_n = HS_IDLE;
                 else if (!ack_n) st_n = HS_FIRST;
      HS_FIRST:  if (ack_n) st_n = HS_GAP;
      HS_GAP:    if (!ack_n) st_n = HS_SECOND;
      HS_SECOND: if (ack_n) st_n = HS_IDLE;
      default:   st_n = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= HS_IDLE;
      sel <= '0;
    end else begin
      st <= st_n;
      if (grab) sel <= cand_idx;
    end
  end

  assert_int_drops_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && !ack_n) |=> !int_out);
  assert_oe_needs_low_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> !ack_n);
  assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe |-> (vec_out == '0));
  assert_int_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> $past(cand_valid));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_LINES   = LINES,
  parameter int unsigned VEC_BITS  = VEC_W,
  parameter int unsigned BASE_INIT = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  irq_req,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [VEC_BITS-1:0] wr_data,
  input  logic                ack_n,
  output logic                int_out,
  output logic [VEC_BITS-1:0] vec_out,
  output logic                vec_oe
);
  localparam int unsigned IW = $clog2(N_LINES);

  logic [N_LINES-1:0]  mask_r;
  logic [VEC_BITS-1:0] base_r;
  logic [N_LINES-1:0]  pend, isr, take;
  logic                eoi_hit;
  logic                cand_valid;
  logic [IW-1:0]       cand_idx;

  assign eoi_hit = wr_en && (wr_addr == REG_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r <= '0;
      base_r <= VEC_BITS'(BASE_INIT);
    end else if (wr_en) begin
      if (wr_addr == REG_MASK) mask_r <= wr_data[N_LINES-1:0];
      if (wr_addr == REG_BASE) base_r <= wr_data;
    end
  end

  irqc_lines #(.N(N_LINES)) u_lines (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .take(take), .eoi(eoi_hit),
    .pending(pend), .in_svc(isr)
  );

  irqc_resolve #(.N(N_LINES)) u_resolve (
    .pending(pend), .mask(mask_r), .in_svc(isr),
    .cand_valid(cand_valid), .cand_idx(cand_idx)
  );

  irqc_handshake #(.N(N_LINES), .VW(VEC_BITS)) u_hs (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_idx(cand_idx),
    .ack_n(ack_n), .base(base_r), .take(take), .int_out(int_out),
    .vec_out(vec_out), .vec_oe(vec_oe)
  );

  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> $past((pend & ~mask_r) != '0));
  assert_take_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take & mask_r) == '0);
  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take != '0) |-> ((((take - 1'b1) & pend & ~mask_r)) == '0));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack_n = 1'b1;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_oe;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_n(ack_n), .int_out(int_out), .vec_out(vec_out), .vec_oe(vec_oe)
  );

  // {request pattern, mask, expect interrupt, expected line}
  localparam logic [19:0] TBL [6] = '{
    {8'h01, 8'h00, 1'b1, 3'd0},
    {8'hA4, 8'h00, 1'b1, 3'd2},
    {8'hA4, 8'h04, 1'b1, 3'd5},
    {8'h30, 8'h30, 1'b0, 3'd0},
    {8'hFF, 8'h7F, 1'b1, 3'd7},
    {8'hC8, 8'h00, 1'b1, 3'd3}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] lines);
    irq_req = lines;
    tick();
    irq_req = '0;
    tick();
  endtask

  task automatic serve(output logic int_after1, output logic [7:0] vec, output logic oe);
    ack_n = 1'b0; tick();
    int_after1 = int_out;
    ack_n = 1'b1; tick();
    ack_n = 1'b0; #1;
    vec = vec_out; oe = vec_oe;
    tick();
    ack_n = 1'b1; tick();
  endtask

  task automatic drain();
    logic i1; logic [7:0] v; logic o;
    irq_req = '0;
    wr(2'd0, 8'h00);
    for (int k = 0; k < 10; k++) begin
      tick();
      if (int_out) begin
        serve(i1, v, o);
        wr(2'd2, 8'h00);
      end
    end
    for (int k = 0; k < 8; k++) wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic i1; logic [7:0] v; logic o;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(int_out == 1'b0, "R1 int after reset", int_out, 0);
    check(vec_oe == 1'b0 && vec_out == 8'h00, "R1 bus after reset", vec_out, 0);
    pulse(8'h08);
    check(int_out == 1'b1, "R1 no mask after reset", int_out, 1);
    serve(i1, v, o);
    check(v == 8'd35 && o, "R1 base 32 after reset", v, 35);
    wr(2'd2, 8'h00);

    // table walk: R3 masking, R4 priority, R5 raise, R6 drop, R7 vector
    for (int t = 0; t < 6; t++) begin
      logic [7:0] rq, mk; logic ev; logic [2:0] ln;
      {rq, mk, ev, ln} = TBL[t];
      wr(2'd0, mk);
      irq_req = rq; tick();
      irq_req = '0;
      check(int_out == 1'b0, "R5 not yet raised", int_out, 0);
      tick();
      check(int_out == ev, "R3 R5 int level", int_out, ev);
      if (ev) begin
        serve(i1, v, o);
        check(i1 == 1'b0, "R6 int drops after first ack", i1, 0);
        check(o == 1'b1, "R7 oe during second pulse", o, 1);
        check(v == 8'd32 + ln, "R4 R7 vector", v, 8'd32 + ln);
        check(vec_oe == 1'b0 && vec_out == 8'h00, "R7 bus quiet after", vec_out, 0);
        wr(2'd2, 8'h00);
      end
      drain();
    end

    // R2 held level does not retrigger
    irq_req = 8'h04; tick(); tick();
    check(int_out == 1'b1, "R2 edge raises", int_out, 1);
    serve(i1, v, o);
    wr(2'd2, 8'h00);
    repeat (4) tick();
    check(int_out == 1'b0, "R2 held level silent", int_out, 0);
    irq_req = '0; tick();

    // R9 no re-entry while in service
    pulse(8'h10);
    serve(i1, v, o);
    check(v == 8'd36, "R9 first service", v, 36);
    pulse(8'h10); tick();
    check(int_out == 1'b0, "R9 blocked while in service", int_out, 0);
    wr(2'd2, 8'h00);
    check(int_out == 1'b0, "R11 not before next edge", int_out, 0);
    tick();
    check(int_out == 1'b1, "R11 reasserts next cycle", int_out, 1);
    serve(i1, v, o);
    check(v == 8'd36, "R9 kept pending", v, 36);
    wr(2'd2, 8'h00);

    // R10 nesting and R11 lowest in-service cleared
    pulse(8'h20);
    serve(i1, v, o);
    pulse(8'h40); tick();
    check(int_out == 1'b0, "R10 line 6 blocked by 5", int_out, 0);
    pulse(8'h04);
    check(int_out == 1'b1, "R10 line 2 preempts 5", int_out, 1);
    serve(i1, v, o);
    check(v == 8'd34, "R10 nested vector", v, 34);
    wr(2'd2, 8'h00);
    pulse(8'h08);
    check(int_out == 1'b1, "R11 eoi released line 2", int_out, 1);
    serve(i1, v, o);
    check(v == 8'd35, "R11 line 3 vector", v, 35);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h00);
    tick();
    check(int_out == 1'b1, "R11 line 6 after 5 retired", int_out, 1);
    serve(i1, v, o);
    check(v == 8'd38, "R11 line 6 vector", v, 38);
    wr(2'd2, 8'h00);

    // R12 withdraw by masking
    pulse(8'h40);
    check(int_out == 1'b1, "R12 raised", int_out, 1);
    wr(2'd0, 8'h40); tick();
    check(int_out == 1'b0, "R12 dropped when masked", int_out, 0);
    wr(2'd0, 8'h00); tick();
    check(int_out == 1'b1, "R12 back when unmasked", int_out, 1);
    serve(i1, v, o);
    wr(2'd2, 8'h00);

    // R8 base and wrap
    wr(2'd1, 8'hF8);
    pulse(8'h80);
    serve(i1, v, o);
    check(v == 8'hFF, "R8 base F8 line 7", v, 8'hFF);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    pulse(8'h02);
    serve(i1, v, o);
    check(v == 8'h00 && o, "R8 wrap to zero", v, 0);
    wr(2'd2, 8'h00);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule